// File: doc/BRIEF.md
# Load/Store Buffer Issue Scheduler

This block keeps memory operations in program order in a small circular buffer and decides, every cycle, which of them are offered to the data cache and which one may take the uncached path. Instruction issue allocates one entry per cycle through a valid/ready stream and is told the slot number it received. Each held entry carries flags: uncached, accepted by the cache, conflicting, waiting for data, done and rejected. The per-cycle status update and the selection scan run in one combinational pass on the registered state. The oldest entry is freed once it is done.

Each cycle the block first releases stores whose data register has become ready. It then releases loads that forward from a store that is no longer waiting and re-evaluates every conflicting entry. Finally it scans from oldest to newest. Cached candidates fill up to `CACHE_W` request lanes in age order. An uncached candidate ends the scan. Back-pressure rules: an allocation transfers on a cycle where `alloc_valid` and `alloc_ready` are both high, and `alloc_ready` depends only on the buffer occupancy. Cache lane valids never depend on `cache_ready`. The cache must accept lanes in order. Lane k counts as accepted only if lanes 0..k-1 were accepted too. The uncached port is a one-cycle pulse the uncached path always takes. Parameter `PRECISE` replaces the per-slot non-speculative mask with "slot equals `grad_slot`" as the uncached issue condition. `DEPTH` must be a power of two.

Top module: `lsb_sched`

## Requirements
- R1: Reset empties the buffer: `alloc_ready`=1, `alloc_slot`=0 and no lane or uncached request is active. `alloc_ready` is high exactly when fewer than DEPTH entries are held. An accepted allocation occupies slot `alloc_slot`, equal to (oldest slot + entries held) mod DEPTH.
- R2: A store allocated with `alloc_data_rdy` low is pending. It stays pending while `st_data_ready[slot]` is low. In the cycle that bit is seen high, its pending and accepted flags clear, so it is offered to the cache again in that same cycle if otherwise eligible.
- R3: A load allocated with `alloc_fwd` high is pending while the store in slot `alloc_fwd_slot` is pending. In the cycle any store leaves the pending state, each such load whose store is no longer pending has its pending and accepted flags cleared.
- R4: A cached entry conflicts when an older held cached entry has the same address, unless the newer one is a load and the older one is a load or the newer one forwards. The flag is re-evaluated every cycle and cleared once no such older entry is held.
- R5: The scan visits entries oldest first and skips done ones. An entry is offered on a cache lane only when it is cached, not accepted and not conflicting. Lanes fill in age order from lane 0, at most CACHE_W per cycle.
- R6: A lane is accepted when its `cache_ready` and all lower lanes are accepted. The first offered lane that is not accepted marks its entry rejected. A rejected entry, when offered again, is the last lane of that cycle. Acceptance clears the rejected flag.
- R7: An entry accepted while not pending becomes done. An entry accepted while pending stays not done and is not offered again until its pending flag clears.
- R8: With PRECISE=0, an uncached entry that is not pending and whose `nonspec` bit is high is the uncached candidate, and no younger entry is examined that cycle. It is issued on `unc_go` only if every lane offered that cycle was accepted. Once issued it becomes done.
- R9: A done entry at the oldest position is freed at the end of the next cycle, so it still counts for conflicts and occupancy during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| alloc_valid | input | 1 | allocation request |
| alloc_ready | output | 1 | buffer has a free entry (low = issue stalls) |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_uncached | input | 1 | operation takes the uncached path |
| alloc_addr | input | AW | operation address |
| alloc_data_rdy | input | 1 | store data register already produced |
| alloc_fwd | input | 1 | load forwards from a held store |
| alloc_fwd_slot | input | SW | slot of that store |
| alloc_slot | output | SW | slot the next allocation takes |
| st_data_ready | input | DEPTH | per slot: store data register is ready |
| nonspec | input | DEPTH | per slot: instruction is non-speculative |
| grad_slot | input | SW | slot of the oldest ungraduated instruction (PRECISE=1) |
| cache_valid | output | CACHE_W | lane carries a request |
| cache_ready | input | CACHE_W | cache accepts the lane |
| cache_slot | output | CACHE_W x SW | slot on each lane |
| cache_addr | output | CACHE_W x AW | address on each lane |
| cache_store | output | CACHE_W | lane is a store |
| unc_go | output | 1 | uncached issue pulse |
| unc_slot | output | SW | slot issued uncached |
| unc_addr | output | AW | address issued uncached |
| unc_store | output | 1 | uncached issue is a store |

## Verification
On every cycle, assertions hold the occupancy count equal to the number of held entries and keep a pending store pending until its data-ready bit arrives. They also check that every offered lane names a held, cached, not-done entry and that an uncached issue is recorded as done. The cycle-exact outcome of the scan can only be shown by the bench's reference model under its scenarios: which entries fill the lanes, how a rejection truncates them, when a forwarding load or a conflicting entry is released, and when the oldest entry frees its slot.

// File: rtl/lsb_pkg.sv
`timescale 1ns/1ps
package lsb_pkg;
  // status flags of one buffer entry
  typedef struct packed {
    logic unc;
    logic acc;
    logic conf;
    logic pend;
    logic done;
    logic rej;
  } lsb_flags_t;
endpackage

// File: rtl/lsb_conflict.sv
`timescale 1ns/1ps
module lsb_conflict #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  localparam int SW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]         vld,
  input  logic [DEPTH-1:0]         unc,
  input  logic [DEPTH-1:0]         st,
  input  logic [DEPTH-1:0]         fwd,
  input  logic [DEPTH-1:0][AW-1:0] addr,
  input  logic [SW-1:0]            head,
  input  logic [DEPTH-1:0]         conf_in,
  input  logic [AW-1:0]            new_addr,
  input  logic                     new_store,
  input  logic                     new_fwd,
  input  logic                     new_unc,
  output logic [DEPTH-1:0]         conf_keep,
  output logic                     new_conf
);
  logic [DEPTH-1:0] still;

  always_comb begin
    still = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < DEPTH; j++) begin
        logic [SW-1:0] ri, rj;
        ri = SW'(i) - head;
        rj = SW'(j) - head;
        if (vld[j] && !unc[j] && (rj < ri) && addr[j] == addr[i] &&
            !(!st[i] && (!st[j] || fwd[i])))
          still[i] = 1'b1;
      end
    end
    conf_keep = conf_in & still;
  end

  always_comb begin
    new_conf = 1'b0;
    for (int j = 0; j < DEPTH; j++)
      if (vld[j] && !unc[j] && addr[j] == new_addr &&
          !(!new_store && (!st[j] || new_fwd)))
        new_conf = !new_unc;
  end
endmodule

// File: rtl/lsb_scan.sv
`timescale 1ns/1ps
module lsb_scan #(
  parameter int DEPTH   = 8,
  parameter int CACHE_W = 2,
  localparam int SW     = $clog2(DEPTH),
  localparam int LW     = (CACHE_W > 1) ? $clog2(CACHE_W) : 1
) (
  input  logic [SW-1:0]               head,
  input  logic [DEPTH-1:0]            vld,
  input  logic [DEPTH-1:0]            done,
  input  logic [DEPTH-1:0]            unc,
  input  logic [DEPTH-1:0]            acc,
  input  logic [DEPTH-1:0]            conf,
  input  logic [DEPTH-1:0]            pend,
  input  logic [DEPTH-1:0]            rej,
  input  logic [DEPTH-1:0]            gate,
  output logic [CACHE_W-1:0]          lane_vld,
  output logic [CACHE_W-1:0][SW-1:0]  lane_slot,
  output logic                        unc_sel,
  output logic [SW-1:0]               unc_pick
);
  always_comb begin
    int n;
    logic stop;
    logic [SW-1:0] idx;
    n = 0;
    stop = 1'b0;
    lane_vld = '0;
    lane_slot = '0;
    unc_sel = 1'b0;
    unc_pick = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + SW'(k);
      if (!stop && vld[idx] && !done[idx]) begin
        if (!unc[idx] && !acc[idx] && !conf[idx]) begin
          lane_vld[n[LW-1:0]] = 1'b1;
          lane_slot[n[LW-1:0]] = idx;
          n = n + 1;
          if (rej[idx] || n == CACHE_W) stop = 1'b1;
        end else if (unc[idx] && !pend[idx] && gate[idx]) begin
          unc_sel = 1'b1;
          unc_pick = idx;
          stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lsb_sched.sv
`timescale 1ns/1ps
module lsb_sched #(
  parameter int DEPTH   = 8,
  parameter int CACHE_W = 2,
  parameter int AW      = 8,
  parameter bit PRECISE = 1'b0,
  localparam int SW     = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_valid,
  output logic                       alloc_ready,
  input  logic                       alloc_store,
  input  logic                       alloc_uncached,
  input  logic [AW-1:0]              alloc_addr,
  input  logic                       alloc_data_rdy,
  input  logic                       alloc_fwd,
  input  logic [SW-1:0]              alloc_fwd_slot,
  output logic [SW-1:0]              alloc_slot,
  input  logic [DEPTH-1:0]           st_data_ready,
  input  logic [DEPTH-1:0]           nonspec,
  input  logic [SW-1:0]              grad_slot,
  output logic [CACHE_W-1:0]         cache_valid,
  input  logic [CACHE_W-1:0]         cache_ready,
  output logic [CACHE_W-1:0][SW-1:0] cache_slot,
  output logic [CACHE_W-1:0][AW-1:0] cache_addr,
  output logic [CACHE_W-1:0]         cache_store,
  output logic                       unc_go,
  output logic [SW-1:0]              unc_slot,
  output logic [AW-1:0]              unc_addr,
  output logic                       unc_store
);
  import lsb_pkg::*;

  lsb_flags_t [DEPTH-1:0]    fl;
  logic [DEPTH-1:0]          vld, st, fwd;
  logic [DEPTH-1:0][AW-1:0]  addr_q;
  logic [DEPTH-1:0][SW-1:0]  fslot_q;
  logic [SW-1:0]             head;
  logic [SW:0]               cnt;

  logic [DEPTH-1:0] unc_v, acc_v, conf_v, pend_v, done_v, rej_v;
  logic [DEPTH-1:0] st_rel, ld_rel, pend_a, pend_now, acc_now, conf_now, gate;
  logic [DEPTH-1:0] take, bounce;
  logic             any_rel, new_conf, new_pend, alloc_fire, release_head;
  logic [CACHE_W-1:0] lane_ok, lane_bad;
  logic             unc_sel, lanes_clear;
  logic [SW-1:0]    unc_pick, tail;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      unc_v[i]  = fl[i].unc;
      acc_v[i]  = fl[i].acc;
      conf_v[i] = fl[i].conf;
      pend_v[i] = fl[i].pend;
      done_v[i] = fl[i].done;
      rej_v[i]  = fl[i].rej;
    end
  end

  // pass 1 and 2: data arrival for stores, then forwarding loads
  always_comb begin
    st_rel  = vld & st & pend_v & st_data_ready;
    any_rel = |st_rel;
    pend_a  = pend_v & ~st_rel;
    for (int i = 0; i < DEPTH; i++)
      ld_rel[i] = vld[i] && !st[i] && pend_v[i] && fwd[i] && any_rel &&
                  !pend_a[fslot_q[i]];
    pend_now = pend_a & ~ld_rel;
    acc_now  = acc_v & ~st_rel & ~ld_rel;
    for (int i = 0; i < DEPTH; i++)
      gate[i] = PRECISE ? (grad_slot == SW'(i)) : nonspec[i];
  end

  // pass 3: conflict re-evaluation and allocation check
  lsb_conflict #(.DEPTH(DEPTH), .AW(AW)) conf_u (
    .vld(vld), .unc(unc_v), .st(st), .fwd(fwd), .addr(addr_q), .head(head),
    .conf_in(conf_v), .new_addr(alloc_addr), .new_store(alloc_store),
    .new_fwd(alloc_fwd), .new_unc(alloc_uncached),
    .conf_keep(conf_now), .new_conf(new_conf)
  );

  // pass 4: selection scan
  lsb_scan #(.DEPTH(DEPTH), .CACHE_W(CACHE_W)) scan_u (
    .head(head), .vld(vld), .done(done_v), .unc(unc_v), .acc(acc_now),
    .conf(conf_now), .pend(pend_now), .rej(rej_v), .gate(gate),
    .lane_vld(cache_valid), .lane_slot(cache_slot),
    .unc_sel(unc_sel), .unc_pick(unc_pick)
  );

  // in-order lane acceptance
  always_comb begin
    logic prefix;
    prefix = 1'b1;
    lanes_clear = 1'b1;
    for (int k = 0; k < CACHE_W; k++) begin
      lane_ok[k]  = cache_valid[k] && cache_ready[k] && prefix;
      lane_bad[k] = cache_valid[k] && !lane_ok[k] && prefix;
      if (cache_valid[k] && !lane_ok[k]) begin
        prefix = 1'b0;
        lanes_clear = 1'b0;
      end
    end
    take = '0;
    bounce = '0;
    for (int i = 0; i < DEPTH; i++)
      for (int k = 0; k < CACHE_W; k++) begin
        if (lane_ok[k] && cache_slot[k] == SW'(i)) take[i] = 1'b1;
        if (lane_bad[k] && cache_slot[k] == SW'(i)) bounce[i] = 1'b1;
      end
  end

  always_comb begin
    for (int k = 0; k < CACHE_W; k++) begin
      cache_addr[k]  = addr_q[cache_slot[k]];
      cache_store[k] = st[cache_slot[k]];
    end
  end

  assign unc_go       = unc_sel && lanes_clear;
  assign unc_slot     = unc_pick;
  assign unc_addr     = addr_q[unc_pick];
  assign unc_store    = st[unc_pick];
  assign alloc_ready  = (cnt != (SW+1)'(DEPTH));
  assign tail         = head + cnt[SW-1:0];
  assign alloc_slot   = tail;
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign release_head = vld[head] && done_v[head];
  assign new_pend     = alloc_store ? !alloc_data_rdy
                                    : (alloc_fwd && vld[alloc_fwd_slot] && pend_now[alloc_fwd_slot]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; st <= '0; fwd <= '0; fl <= '0;
      addr_q <= '0; fslot_q <= '0; head <= '0; cnt <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (vld[i]) begin
          fl[i].pend <= pend_now[i];
          fl[i].acc  <= acc_now[i] | take[i];
          fl[i].conf <= conf_now[i];
          fl[i].done <= done_v[i] | (take[i] & ~pend_now[i]) |
                        (unc_go && unc_pick == SW'(i));
          fl[i].rej  <= (rej_v[i] | bounce[i]) & ~take[i];
        end
      end
      if (release_head) vld[head] <= 1'b0;
      if (alloc_fire) begin
        vld[tail]     <= 1'b1;
        st[tail]      <= alloc_store;
        fwd[tail]     <= alloc_fwd && !alloc_store;
        addr_q[tail]  <= alloc_addr;
        fslot_q[tail] <= alloc_fwd_slot;
        fl[tail]      <= '{unc: alloc_uncached, acc: 1'b0, conf: new_conf,
                           pend: new_pend, done: 1'b0, rej: 1'b0};
      end
      head <= head + SW'(release_head);
      cnt  <= cnt + (SW+1)'(alloc_fire) - (SW+1)'(release_head);
    end
  end

  // R1
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == ($countones(vld)))
    else $error("entry count disagrees with held entries");

  // R8
  unc_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unc_go |=> done_v[$past(unc_slot)])
    else $error("uncached issue not recorded as done");

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      // R2
      store_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[g] && st[g] && pend_v[g] && !st_data_ready[g]) |=> (vld[g] && pend_v[g]))
        else $error("store left pending state without data");
    end
    for (genvar k = 0; k < CACHE_W; k++) begin : g_lane
      // R5
      lane_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_valid[k] |-> (vld[cache_slot[k]] && !done_v[cache_slot[k]] && !unc_v[cache_slot[k]]))
        else $error("lane offers an ineligible entry");
    end
  endgenerate
endmodule

// File: tb/lsb_sched_tb.sv
`timescale 1ns/1ps
module lsb_sched_tb_top;
  localparam int D  = 8;
  localparam int CW = 2;
  localparam int AW = 8;
  localparam int SW = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic a_valid = 0, a_st = 0, a_unc = 0, a_drdy = 1, a_fwd = 0;
  logic [AW-1:0] a_addr = '0;
  logic [SW-1:0] a_fslot = '0;
  logic [D-1:0]  dr = '0, ns = '1;
  logic [SW-1:0] gslot = '0;
  logic [CW-1:0] crdy = '1;

  logic alloc_ready, unc_go, unc_store;
  logic [SW-1:0] alloc_slot, unc_slot;
  logic [AW-1:0] unc_addr;
  logic [CW-1:0] cache_valid, cache_store;
  logic [CW-1:0][SW-1:0] cache_slot;
  logic [CW-1:0][AW-1:0] cache_addr;

  lsb_sched #(.DEPTH(D), .CACHE_W(CW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(a_valid), .alloc_ready(alloc_ready), .alloc_store(a_st),
    .alloc_uncached(a_unc), .alloc_addr(a_addr), .alloc_data_rdy(a_drdy),
    .alloc_fwd(a_fwd), .alloc_fwd_slot(a_fslot), .alloc_slot(alloc_slot),
    .st_data_ready(dr), .nonspec(ns), .grad_slot(gslot),
    .cache_valid(cache_valid), .cache_ready(crdy), .cache_slot(cache_slot),
    .cache_addr(cache_addr), .cache_store(cache_store),
    .unc_go(unc_go), .unc_slot(unc_slot), .unc_addr(unc_addr), .unc_store(unc_store)
  );

  typedef struct {
    int slot; int addr; bit st; bit unc; bit fwd; int fslot;
    bit pend; bit acc; bit conf; bit done; bit rej;
  } ent_t;
  ent_t q[$];
  int hd = 0;
  int nchk = 0, nerr = 0;
  string cur = "R1";

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s (%s) act=%0d exp=%0d at %0t", cur, what, act, exp, $time);
    end
  endtask

  function automatic bit clash(input ent_t o, input ent_t n);
    return !o.unc && o.addr == n.addr && !(!n.st && (!o.st || n.fwd));
  endfunction

  // one cycle of the reference model, compared against the outputs
  task automatic step();
    bit any, rel, prefix, lclear;
    int nl, uidx;
    int lidx[CW];
    bit lv[CW];
    int e_slot;
    bit e_ready;
    #1;
    any = 0;
    foreach (q[i]) if (q[i].st && q[i].pend && dr[q[i].slot]) begin
      q[i].pend = 0; q[i].acc = 0; any = 1;
    end
    if (any) foreach (q[i]) if (!q[i].st && q[i].pend && q[i].fwd) begin
      bit sp; sp = 0;
      foreach (q[j]) if (q[j].slot == q[i].fslot) sp = q[j].pend;
      if (!sp) begin q[i].pend = 0; q[i].acc = 0; end
    end
    foreach (q[i]) if (q[i].conf) begin
      bit c; c = 0;
      for (int j = 0; j < i; j++) if (clash(q[j], q[i])) c = 1;
      q[i].conf = c;
    end
    nl = 0; uidx = -1;
    for (int k = 0; k < CW; k++) begin lv[k] = 0; lidx[k] = 0; end
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].done) continue;
      if (!q[i].unc && !q[i].acc && !q[i].conf) begin
        lv[nl] = 1; lidx[nl] = i; nl++;
        if (q[i].rej || nl == CW) break;
      end else if (q[i].unc && !q[i].pend && ns[q[i].slot]) begin
        uidx = i; break;
      end
    end
    prefix = 1; lclear = 1;
    e_ready = q.size() < D;
    e_slot = (hd + q.size()) % D;
    chk(alloc_ready == e_ready, "R1 alloc_ready", alloc_ready, e_ready);
    chk(alloc_slot == e_slot[SW-1:0], "R1 alloc_slot", alloc_slot, e_slot);
    for (int k = 0; k < CW; k++) begin
      chk(cache_valid[k] == lv[k], "R5 lane valid", cache_valid[k], lv[k]);
      if (lv[k] && cache_valid[k]) begin
        chk(cache_slot[k] == q[lidx[k]].slot[SW-1:0], "R5 lane slot", cache_slot[k], q[lidx[k]].slot);
        chk(cache_addr[k] == q[lidx[k]].addr[AW-1:0], "R5 lane addr", cache_addr[k], q[lidx[k]].addr);
      end
    end
    rel = q.size() > 0 && q[0].done;
    for (int k = 0; k < CW; k++) if (lv[k]) begin
      if (prefix && crdy[k]) begin
        q[lidx[k]].acc = 1; q[lidx[k]].rej = 0;
        if (!q[lidx[k]].pend) q[lidx[k]].done = 1;
      end else begin
        if (prefix) q[lidx[k]].rej = 1;
        prefix = 0; lclear = 0;
      end
    end
    chk(unc_go == (uidx >= 0 && lclear), "R8 unc_go", unc_go, uidx >= 0 && lclear);
    if (uidx >= 0 && lclear) begin
      chk(unc_slot == q[uidx].slot[SW-1:0], "R8 unc_slot", unc_slot, q[uidx].slot);
      q[uidx].done = 1;
    end
    if (a_valid && e_ready) begin
      ent_t n;
      n.slot = e_slot; n.addr = a_addr; n.st = a_st; n.unc = a_unc;
      n.fwd = a_fwd && !a_st; n.fslot = a_fslot;
      n.acc = 0; n.done = 0; n.rej = 0; n.conf = 0; n.pend = 0;
      if (a_st) n.pend = !a_drdy;
      else if (n.fwd) foreach (q[j]) if (q[j].slot == a_fslot) n.pend = q[j].pend;
      if (!a_unc) foreach (q[j]) if (clash(q[j], n)) n.conf = 1;
      if (rel) begin void'(q.pop_front()); hd = (hd + 1) % D; end
      q.push_back(n);
    end else if (rel) begin
      void'(q.pop_front()); hd = (hd + 1) % D;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input bit s, input bit u, input int ad, input bit drd, input bit fw, input int fs);
    a_valid = 1; a_st = s; a_unc = u; a_addr = AW'(ad); a_drdy = drd;
    a_fwd = fw; a_fslot = SW'(fs);
    step();
    a_valid = 0; a_fwd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(8 * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    cur = "R1";
    chk(alloc_ready == 1 && alloc_slot == 0 && cache_valid == 0 && unc_go == 0,
        "R1 reset state", {alloc_ready, cache_valid, unc_go}, 4'b1000);
    // R5 R7 R9: plain cached loads, full acceptance
    cur = "R5";
    put(0, 0, 8'h10, 1, 0, 0); put(0, 0, 8'h11, 1, 0, 0); put(0, 0, 8'h12, 1, 0, 0);
    cur = "R9"; idle(4);
    // R6: cache rejects, rejected entry retried alone
    cur = "R6"; crdy = 2'b00;
    put(0, 0, 8'h20, 1, 0, 0); put(0, 0, 8'h21, 1, 0, 0); idle(2);
    crdy = 2'b01; idle(3); crdy = 2'b11; idle(3);
    // R1: fill the buffer while the cache is closed
    cur = "R1"; crdy = 2'b00;
    for (int i = 0; i < D; i++) put(0, 0, 8'h30 + i, 1, 0, 0);
    a_valid = 1; #1;
    chk(alloc_ready == 0, "R1 full stall", alloc_ready, 0);
    step(); a_valid = 0;
    crdy = 2'b11; idle(8);
    // R2 R3 R7: pending store, forwarding load, late data
    cur = "R2";
    put(1, 0, 8'h50, 0, 0, 0);
    cur = "R3";
    put(0, 0, 8'h50, 1, 1, q[q.size()-1].slot);
    cur = "R7"; idle(3);
    cur = "R2"; dr[q[0].slot] = 1'b1; idle(1); dr = '0;
    cur = "R3"; idle(4);
    // R4: load after store to the same address waits
    cur = "R4"; crdy = 2'b00;
    put(1, 0, 8'h60, 1, 0, 0); put(0, 0, 8'h60, 1, 0, 0); put(0, 0, 8'h61, 1, 0, 0);
    crdy = 2'b11; idle(6);
    // R8: uncached load waits for non-speculative, blocks younger entries
    cur = "R8"; ns = '0;
    put(0, 1, 8'h70, 1, 0, 0); put(0, 0, 8'h71, 1, 0, 0); idle(2);
    ns = '1; idle(4);
    // random mix
    cur = "R5";
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = $urandom % 4;
      crdy = CW'((1 << ($urandom % (CW + 1))) - 1);
      dr = D'($urandom) & D'($urandom);
      ns = D'($urandom) | D'($urandom);
      a_valid = ($urandom % 2) == 1;
      a_st = ($urandom % 2) == 1;
      a_unc = ($urandom % 6) == 0;
      a_addr = AW'(8'h40 + r);
      a_drdy = ($urandom % 2) == 1;
      a_fwd = 0; a_fslot = '0;
      if (!a_st && !a_unc && ($urandom % 2) == 1)
        foreach (q[j]) if (q[j].st && !q[j].unc) begin
          a_fwd = 1; a_fslot = SW'(q[j].slot);
        end
      step();
    end
    a_valid = 0; a_fwd = 0; crdy = '1; dr = '1; ns = '1;
    cur = "R9";
    for (int i = 0; i < 40 && q.size() > 0; i++) step();
    chk(q.size() == 0 && alloc_ready == 1, "R9 drained", q.size(), 0);
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule